// File: doc/BRIEF.md
# Clocked Serial Slave Transmitter

This block sends bytes out of a chip on a single data line, paced by a serial clock that an outside master drives. The local side hands it one word at a time over a valid/ready write channel. The word waits in a one-entry holding buffer until the master starts a frame. It then moves into a shift register and goes out one bit at a time. The serial clock pin is not used as a clock. A synchronizer samples it with the faster local operation clock, and edge detection in that domain paces every action. For this reason the serial clock may run at no more than one sixth of the operation clock.

Static configuration pins set the following:
- the frame size: a full word or one bit shorter;
- which end of the word goes first;
- whether the serial clock idles low or high;
- whether the first bit is placed on the line before the first clock edge or at it;
- whether the interrupt marks the end of a frame or the moment the holding buffer is emptied.

If a frame starts while the buffer is empty, the block sends the old buffer contents again. It also raises a sticky overrun flag, which a write-one-to-clear pulse removes.

Back-pressure rules for the write channel:
- `wr_ready` is high exactly while the holding buffer is empty.
- A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high.
- While `wr_ready` is low, `wr_valid` and `wr_data` have no effect. The source may hold its word until ready returns.

Configuration pins must only change while no frame is in progress.

Top module: `sser_slave_tx`

## Requirements
- R1: `wr_ready` is 1 exactly while the holding buffer is empty. A write with `wr_valid`=1 and `wr_ready`=1 fills it, so `wr_ready` is 0 from the next cycle. A write offered while `wr_ready`=0 changes neither the buffer nor any later output.
- R2: With `cfg_short`=0 a frame is DATA_W bits (8 by default). With `cfg_short`=1 it is DATA_W-1 bits, taken from the low DATA_W-1 bits of the word. The frame ends on the trailing serial clock edge that follows its last leading edge.
- R3: With `cfg_lsb_first`=1, bit k of a frame is word bit k. With `cfg_lsb_first`=0, bit k is word bit (L-1-k), where L is the frame length.
- R4: With `cfg_clk_inv`=0, the leading edge is a rising edge of `sclk_in` and the clock idles low. With `cfg_clk_inv`=1, the leading edge is a falling edge and the clock idles high.
- R5: With `cfg_early`=0, bit k is driven after leading edge k, and a master samples it on the trailing edge. With `cfg_early`=1, bit 0 is already on `sdo` before the first leading edge, bit k+1 is driven after trailing edge k, and a master samples on leading edges.
- R6: While no frame is in progress, `sdo` shows the first bit that the next frame would send from the current buffer contents.
- R7: With `cfg_stream`=0, `irq` is a one-cycle pulse after the trailing edge that ends each frame.
- R8: With `cfg_stream`=1, `irq` is a one-cycle pulse when a frame start takes a word out of a full buffer. Frames follow each other with no idle serial clock between them.
- R9: A frame that starts while the buffer is empty sends the last word written again, sets `ovr_flag`, and gives no `irq` in stream mode. `ovr_flag` stays set until cleared.
- R10: A cycle with `ovr_clr`=1 clears `ovr_flag`, unless a new overrun is detected in the same cycle, in which case the flag stays set.
- R11: A change on `sclk_in` takes effect on `sdo`, `irq` and `ovr_flag` on the third rising operation-clock edge after it. Correct frames are guaranteed for serial clock rates up to one sixth of the operation clock.
- R12: During and right after reset, `wr_ready`=1, `sdo`=0, `irq`=0 and `ovr_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the external master |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Holding buffer empty, write will be taken |
| wr_data | input | DATA_W | Word to transmit |
| cfg_short | input | 1 | 1: frame one bit shorter than DATA_W |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_clk_inv | input | 1 | 1: serial clock idles high |
| cfg_early | input | 1 | 1: first bit driven half a period before the clock |
| cfg_stream | input | 1 | 1: interrupt on buffer empty, else on frame end |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | One-cycle interrupt pulse |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Suppose the bit counter or the shift register is wrong, or a start is seen where none happened. The fault shows on `sdo` within one serial clock half-period, and a reference model compared on every operation clock catches it in that cycle. A wrong buffer-full state shows on `wr_ready` one cycle after the write, or as a missed or extra `ovr_flag` three cycles after the next leading edge. A wrong choice of interrupt source shows as an `irq` pulse at the wrong edge: the start of a frame instead of its end. As a second, independent check, the words the bench collects at the master's sampling points are compared with the words it wrote.

// File: rtl/sser_pkg.sv
package sser_pkg;

  // Static transfer configuration, sampled every cycle
  typedef struct packed {
    logic short_frame;  // frame is one bit shorter than the data word
    logic lsb_first;    // least significant bit leaves first
    logic clk_inv;      // serial clock idles high
    logic early_data;   // first bit valid before the first leading edge
    logic stream_mode;  // interrupt on buffer empty instead of frame end
  } sser_cfg_t;

endpackage

// File: rtl/sser_edge_sync.sv
module sser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic invert,
  output logic lead_evt,
  output logic trail_evt
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= sclk_pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  logic view_now;
  logic view_old;

  always_comb begin
    view_now  = chain[STAGES-1] ^ invert;
    view_old  = chain[STAGES]   ^ invert;
    lead_evt  = view_now & ~view_old;
    trail_evt = ~view_now & view_old;
  end

endmodule

// File: rtl/sser_txbuf.sv
module sser_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              take,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_full,
  output logic              ovr_flag
);

  logic accept;
  logic starve;

  always_comb begin
    accept   = wr_valid && !buf_full;
    starve   = take && !buf_full;
    wr_ready = !buf_full;
  end

  // Holding register keeps the last word even after it is taken,
  // so a starved frame can send it again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0;
    end else if (accept) begin
      buf_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
    end else begin
      if (take && buf_full) buf_full <= 1'b0;
      if (accept)           buf_full <= 1'b1;
    end
  end

  // Sticky overrun, a new detection wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
    end else if (starve) begin
      ovr_flag <= 1'b1;
    end else if (ovr_clr) begin
      ovr_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sser_shifter.sv
module sser_shifter
  import sser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_evt,
  input  logic              trail_evt,
  input  sser_cfg_t         cfg,
  input  logic [DATA_W-1:0] buf_data,
  output logic              start,
  output logic              done,
  output logic              sdo
);

  localparam int CW = $clog2(DATA_W + 1);

  logic              active;
  logic [CW-1:0]     lead_cnt;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     frame_len;
  logic              last_lead;
  logic              shift_now;
  logic [DATA_W-1:0] load_val;
  logic              out_bit;
  logic              idle_bit;

  always_comb begin
    frame_len = cfg.short_frame ? CW'(DATA_W - 1) : CW'(DATA_W);
    last_lead = (lead_cnt == frame_len);
    start     = lead_evt && !active;
    done      = trail_evt && active && last_lead;
    if (cfg.early_data) shift_now = active && trail_evt && !last_lead;
    else                shift_now = active && lead_evt;
  end

  // Alignment: LSB-first leaves from bit 0, MSB-first from the top bit,
  // so a short MSB-first frame is pushed up by one place.
  always_comb begin
    if (cfg.lsb_first)        load_val = buf_data;
    else if (cfg.short_frame) load_val = buf_data << 1;
    else                      load_val = buf_data;
  end

  always_comb begin
    out_bit = cfg.lsb_first ? shreg[0] : shreg[DATA_W-1];
    if (cfg.lsb_first)        idle_bit = buf_data[0];
    else if (cfg.short_frame) idle_bit = buf_data[DATA_W-2];
    else                      idle_bit = buf_data[DATA_W-1];
    sdo = active ? out_bit : idle_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
    end else if (done) begin
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt <= '0;
    end else if (start) begin
      lead_cnt <= CW'(1);
    end else if (active && lead_evt && !last_lead) begin
      lead_cnt <= lead_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (start) begin
      shreg <= load_val;
    end else if (shift_now) begin
      if (cfg.lsb_first) shreg <= shreg >> 1;
      else               shreg <= shreg << 1;
    end
  end

endmodule

// File: rtl/sser_slave_tx.sv
module sser_slave_tx
  import sser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_short,
  input  logic              cfg_lsb_first,
  input  logic              cfg_clk_inv,
  input  logic              cfg_early,
  input  logic              cfg_stream,
  input  logic              ovr_clr,
  output logic              sdo,
  output logic              irq,
  output logic              ovr_flag
);

  sser_cfg_t         cfg;
  logic              lead_evt;
  logic              trail_evt;
  logic              frame_start;
  logic              frame_done;
  logic [DATA_W-1:0] buf_data;
  logic              buf_full;

  always_comb begin
    cfg.short_frame = cfg_short;
    cfg.lsb_first   = cfg_lsb_first;
    cfg.clk_inv     = cfg_clk_inv;
    cfg.early_data  = cfg_early;
    cfg.stream_mode = cfg_stream;
  end

  sser_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_pin (sclk_in),
    .invert   (cfg.clk_inv),
    .lead_evt (lead_evt),
    .trail_evt(trail_evt)
  );

  sser_txbuf #(
    .DATA_W(DATA_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .take    (frame_start),
    .ovr_clr (ovr_clr),
    .buf_data(buf_data),
    .buf_full(buf_full),
    .ovr_flag(ovr_flag)
  );

  sser_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .lead_evt (lead_evt),
    .trail_evt(trail_evt),
    .cfg      (cfg),
    .buf_data (buf_data),
    .start    (frame_start),
    .done     (frame_done),
    .sdo      (sdo)
  );

  // Interrupt source select, registered to a single-cycle pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (cfg.stream_mode) begin
      irq <= frame_start && buf_full;
    end else begin
      irq <= frame_done;
    end
  end

endmodule

// File: rtl/sser_slave_tx_chk.sv
module sser_slave_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_fire,
  input logic       wr_ready,
  input logic       irq,
  input logic       ovr_flag,
  input logic       ovr_clr,
  input logic       sdo,
  input logic       lead_evt,
  input logic       trail_evt,
  input logic [4:0] cfg_bits
);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_ready); // R1

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(lead_evt || trail_evt)); // R8

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag); // R9

  AST_OVR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(wr_ready && lead_evt)); // R9

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !lead_evt) |=> !ovr_flag); // R10

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lead_evt && !trail_evt && !wr_fire) |=> ($stable(sdo) || !$stable(cfg_bits))); // R6

endmodule

bind sser_slave_tx sser_slave_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_fire  (wr_valid && wr_ready),
  .wr_ready (wr_ready),
  .irq      (irq),
  .ovr_flag (ovr_flag),
  .ovr_clr  (ovr_clr),
  .sdo      (sdo),
  .lead_evt (lead_evt),
  .trail_evt(trail_evt),
  .cfg_bits ({cfg_short, cfg_lsb_first, cfg_clk_inv, cfg_early, cfg_stream})
);

// File: tb/test_sser_slave_tx.sv
module test_sser_slave_tx;

  localparam int H = 4;  // serial half period in operation clocks (rate 1/8)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_in = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cfg_short = 1'b0, cfg_lsb_first = 1'b0, cfg_clk_inv = 1'b0;
  logic       cfg_early = 1'b0, cfg_stream = 1'b0, ovr_clr = 1'b0;
  logic       wr_ready, sdo, irq, ovr_flag;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sser_slave_tx i_sser_slave_tx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cfg_short(cfg_short), .cfg_lsb_first(cfg_lsb_first),
    .cfg_clk_inv(cfg_clk_inv), .cfg_early(cfg_early), .cfg_stream(cfg_stream),
    .ovr_clr(ovr_clr), .sdo(sdo), .irq(irq), .ovr_flag(ovr_flag)
  );

  // ---------------- behavioural reference model ----------------
  logic       m_s1, m_s2, m_s3;
  logic       m_act, m_full, m_irq, m_ovr;
  logic [7:0] m_buf, m_frame;
  int         m_leads, m_k;

  function automatic int flen();
    return cfg_short ? 7 : 8;
  endfunction

  function automatic logic bit_at(logic [7:0] d, int k);
    return cfg_lsb_first ? d[k] : d[flen() - 1 - k];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      m_act <= 0; m_full <= 0; m_irq <= 0; m_ovr <= 0;
      m_buf <= 0; m_frame <= 0; m_leads <= 0; m_k <= 0;
    end else begin
      logic vn, vo, lead, trail, st, fin;
      vn = m_s2 ^ cfg_clk_inv;
      vo = m_s3 ^ cfg_clk_inv;
      lead  = vn && !vo;
      trail = !vn && vo;
      st  = lead && !m_act;
      fin = trail && m_act && (m_leads == flen());
      m_irq <= cfg_stream ? (st && m_full) : fin;
      if (ovr_clr) m_ovr <= 0;
      if (st) begin
        m_frame <= m_buf; m_act <= 1; m_leads <= 1; m_k <= 0;
        if (m_full) m_full <= 0; else m_ovr <= 1;
      end else if (m_act && lead) begin
        m_leads <= m_leads + 1;
        if (!cfg_early) m_k <= m_k + 1;
      end
      if (fin) m_act <= 0;
      else if (m_act && trail && cfg_early && m_leads != flen()) m_k <= m_k + 1;
      if (wr_valid && !m_full) begin m_buf <= wr_data; m_full <= 1; end
      m_s1 <= sclk_in; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic exp_sdo;
      exp_sdo = m_act ? bit_at(m_frame, m_k) : bit_at(m_buf, 0);
      total += 4;
      if (sdo !== exp_sdo) begin bad++; $display("FAIL R5 sdo act=%0b exp=%0b t=%0t", sdo, exp_sdo, $time); end
      if (irq !== m_irq) begin bad++; $display("FAIL R7 irq act=%0b exp=%0b t=%0t", irq, m_irq, $time); end
      if (ovr_flag !== m_ovr) begin bad++; $display("FAIL R9 ovr act=%0b exp=%0b t=%0t", ovr_flag, m_ovr, $time); end
      if (wr_ready !== !m_full) begin bad++; $display("FAIL R1 ready act=%0b exp=%0b t=%0t", wr_ready, !m_full, $time); end
      if (irq) irq_cnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  // Acts as the master: drives one frame and collects sdo at its sampling points
  task automatic run_frame(input int n, input bit lead_done, output logic [7:0] w);
    logic lead_lvl;
    lead_lvl = !cfg_clk_inv;
    w = 0;
    for (int i = 0; i < n; i++) begin
      if (!(lead_done && i == 0)) begin
        if (cfg_early) w[cfg_lsb_first ? i : n - 1 - i] = sdo;
        sclk_in = lead_lvl;
        wait_n(H);
      end
      if (!cfg_early) w[cfg_lsb_first ? i : n - 1 - i] = sdo;
      sclk_in = !lead_lvl;
      wait_n(H);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] w, w2;
    wait_n(3);
    check("R12 ready", {7'd0, wr_ready}, 8'd1);
    check("R12 sdo", {7'd0, sdo}, 8'd0);
    check("R12 irq", {7'd0, irq}, 8'd0);
    check("R12 ovr", {7'd0, ovr_flag}, 8'd0);
    rst_n = 1;
    wait_n(4);

    // S1: single, MSB first, 8 bits, data at clock start; write while full ignored
    write_word(8'hA5);
    check("R1 ready low when full", {7'd0, wr_ready}, 8'd0);
    wr_valid = 1; wr_data = 8'h3C; wait_n(3); wr_valid = 0;
    irq_cnt = 0;
    run_frame(8, 0, w);
    check("R1 R2 R3 msb 8-bit word", w, 8'hA5);
    wait_n(6);
    check("R7 single-mode irq count", irq_cnt[7:0], 8'd1);
    check("R1 ready after take", {7'd0, wr_ready}, 8'd1);

    // S2: single, LSB first, 7 bits, early data
    cfg_lsb_first = 1; cfg_short = 1; cfg_early = 1;
    write_word(8'h4B);
    wait_n(1);
    check("R6 idle sdo first bit", {7'd0, sdo}, 8'd1);
    run_frame(7, 0, w);
    check("R2 R3 R5 lsb 7-bit early", w, 8'h4B);
    wait_n(6);

    // S2b: MSB first, 7 bits, early data; idle shows word bit 6
    cfg_lsb_first = 0;
    write_word(8'h3A);
    wait_n(1);
    check("R6 idle sdo msb short", {7'd0, sdo}, 8'd0);
    run_frame(7, 0, w);
    check("R3 R5 msb 7-bit early", w, 8'h3A);
    wait_n(6);

    // S3: stream mode, back-to-back frames
    cfg_short = 0; cfg_early = 0; cfg_stream = 1;
    write_word(8'h31);
    irq_cnt = 0;
    fork
      begin run_frame(8, 0, w); run_frame(8, 0, w2); end
      begin wait_n(2 * H + 2); write_word(8'hC7); end
    join
    check("R8 stream first word", w, 8'h31);
    check("R8 stream second word", w2, 8'hC7);
    wait_n(6);
    check("R8 stream irq count", irq_cnt[7:0], 8'd2);
    check("R9 no overrun yet", {7'd0, ovr_flag}, 8'd0);

    // S4: starved frame, latency of the overrun flag
    irq_cnt = 0;
    sclk_in = 1;
    wait_n(2);
    check("R11 ovr not yet at 2", {7'd0, ovr_flag}, 8'd0);
    wait_n(1);
    check("R11 ovr set at 3", {7'd0, ovr_flag}, 8'd1);
    wait_n(H - 3);
    run_frame(8, 1, w);
    check("R9 stale word resent", w, 8'hC7);
    wait_n(6);
    check("R9 overrun sticky", {7'd0, ovr_flag}, 8'd1);
    check("R9 no irq when starved", irq_cnt[7:0], 8'd0);
    ovr_clr = 1; wait_n(1); ovr_clr = 0;
    check("R10 overrun cleared", {7'd0, ovr_flag}, 8'd0);

    // S5: inverted clock, single mode
    cfg_stream = 0;
    cfg_clk_inv = 1; wait_n(4);
    sclk_in = 1; wait_n(6);
    write_word(8'h96);
    irq_cnt = 0;
    run_frame(8, 0, w);
    check("R4 inverted clock word", w, 8'h96);
    wait_n(6);
    check("R4 R7 inverted irq count", irq_cnt[7:0], 8'd1);
    check("R9 no overrun inverted", {7'd0, ovr_flag}, 8'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule